// File: doc/BRIEF.md
# Synchronous Cycle and Byte-Write Decoder

This block sits in front of the burst counter and storage array of a pipelined synchronous SRAM. On every rising clock edge it samples the chip-enable and select inputs, the two address-start strobes, the advance input, the global write input, the byte-write gate and the per-lane byte selects. It classifies the cycle and registers the result. It then issues an address-load pulse, an advance pulse and an active-high write strobe per byte lane to the neighbouring counter and array.

A small state machine records whether a burst is live. It has two states. `ST_IDLE` is entered at reset and by every deselect. `ST_BURST` is entered by any read or write begin. From `ST_IDLE`, a begin moves to `ST_BURST` and a deselect stays in `ST_IDLE`. From `ST_BURST`, a deselect returns to `ST_IDLE`. A begin, continue or suspend keeps the current state. A continue or suspend cycle while idle does nothing.

A start through the processor strobe is always a read begin, even when write controls are asserted. The write controls are only looked at on the following edge, where they act as a continue or suspend write. Every output changes one clock after the edge that sampled its inputs.

Top module: `sram_cycle_decoder`

## Requirements
- R1: After reset, `cyc_kind` is 0 (deselect), and `load_addr`, `advance`, `lane_wr` and `chip_active` are all zero.
- R2: The device counts as selected only when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. Two cases give a deselect (`cyc_kind`=0), with `chip_active` 0 and no load, advance or write. The first is `en_n`=1 with `cstrb_n`=0. The second is `en_n`=0 with either strobe low while the device is not selected.
- R3: A selected start with `pstrb_n`=0 is a read begin (`cyc_kind`=1), with `load_addr`=1 and `lane_wr`=0. This holds whatever `gwr_n`, `bwr_n`, `lane_n` and `cstrb_n` are.
- R4: A selected start with `pstrb_n`=1 and `cstrb_n`=0 is a write begin (`cyc_kind`=2, `load_addr`=1) in two cases: `gwr_n`=0, or `bwr_n`=0 with at least one `lane_n` bit low. Otherwise it is a read begin (`cyc_kind`=1) with no write.
- R5: When `cstrb_n`=1 and the strobe case is not covered above (`pstrb_n`=1, or `en_n`=1), the cycle is a continue or a suspend. `adv_n`=0 gives a continue (`cyc_kind`=3, `advance`=1). `adv_n`=1 gives a suspend (`cyc_kind`=4, `advance`=0). The values of `en_n` and the selects do not matter.
- R6: In a write begin, continue or suspend cycle, `gwr_n`=0 sets every `lane_wr` bit, whatever `bwr_n` and `lane_n` are.
- R7: When `gwr_n`=1 and `bwr_n`=1, `lane_wr` is all zero. When `gwr_n`=1 and `bwr_n`=0, `lane_wr[i]` equals the inverse of `lane_n[i]`, and several lanes may be set together. Bit i strobes data bits 8i..8i+7 and parity bit i of the array, a 9-bit lane.
- R8: `LANES` selects 4 or 2 byte lanes, and `lane_wr` and `lane_n` have one bit per lane.
- R9: A continue or suspend cycle in `ST_IDLE` is a no-operation (`cyc_kind`=5). It gives no load, no advance and no write, and `chip_active` stays 0.
- R10: `chip_active` becomes 1 one clock after any read or write begin. It becomes 0 one clock after a deselect, and otherwise it holds.
- R11: The write controls that come with a processor-strobe start take effect on the next edge: a continue or suspend cycle right after that start writes according to R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Chip enable, active low; gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| pstrb_n | input | 1 | Processor address-start strobe, active low |
| cstrb_n | input | 1 | Controller address-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write gate, active low |
| lane_n | input | LANES | Per-lane byte selects, active low |
| cyc_kind | output | 3 | Cycle class: 0 deselect, 1 read begin, 2 write begin, 3 continue, 4 suspend, 5 no-op |
| load_addr | output | 1 | Load external address into the burst counter |
| advance | output | 1 | Step the burst counter |
| lane_wr | output | LANES | Write strobe per 9-bit lane, active high |
| chip_active | output | 1 | Registered flag: a burst is live |

## Verification
Two functions can collide in one edge. The first is the strobe classification, where a start, a deselect and a continue compete for the same cycle. The second is the lane-write decode, where global write, the byte gate and the lane selects compete for the strobes. The bench provokes the collision by asserting both strobes together, by pulling the processor strobe with chip enable high, and by driving global write together with a processor-strobe start. It also runs a long pseudo-random stream. A behavioural model predicts the class, the pulses and the lane vector for each edge, and every clock is judged against that model.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
    typedef enum logic [2:0] {
        CYC_DESEL  = 3'd0,
        CYC_RD_BEG = 3'd1,
        CYC_WR_BEG = 3'd2,
        CYC_CONT   = 3'd3,
        CYC_SUSP   = 3'd4,
        CYC_NOP    = 3'd5
    } cyc_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } dec_state_e;
endpackage

// File: rtl/cyc_classify.sv
module cyc_classify
    import sram_cyc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             en_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             burst_live,
    output cyc_kind_e        kind
);
    logic selected;
    logic any_lane;
    logic wants_write;

    assign selected    = !en_n && sel_hi && !sel_lo_n;
    assign any_lane    = !(&lane_n);
    assign wants_write = !gwr_n || (!bwr_n && any_lane);

    always_comb begin
        if (en_n && !cstrb_n) begin
            kind = CYC_DESEL;
        end else if (!en_n && (!pstrb_n || !cstrb_n) && !selected) begin
            kind = CYC_DESEL;
        end else if (!en_n && !pstrb_n) begin
            kind = CYC_RD_BEG;
        end else if (!cstrb_n) begin
            kind = wants_write ? CYC_WR_BEG : CYC_RD_BEG;
        end else if (!burst_live) begin
            kind = CYC_NOP;
        end else begin
            kind = adv_n ? CYC_SUSP : CYC_CONT;
        end
    end
endmodule

// File: rtl/lane_wr_gen.sv
module lane_wr_gen
    import sram_cyc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  cyc_kind_e        kind,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] wr
);
    logic write_slot;

    assign write_slot = (kind == CYC_WR_BEG) || (kind == CYC_CONT) || (kind == CYC_SUSP);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr[i] = write_slot && (!gwr_n || (!bwr_n && !lane_n[i]));
    end
endmodule

// File: rtl/sram_cycle_decoder.sv
module sram_cycle_decoder
    import sram_cyc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [2:0]       cyc_kind,
    output logic             load_addr,
    output logic             advance,
    output logic [LANES-1:0] lane_wr,
    output logic             chip_active
);
    dec_state_e       state_q;
    dec_state_e       state_d;
    cyc_kind_e        kind_now;
    logic [LANES-1:0] wr_now;

    cyc_classify #(.LANES(LANES)) u_classify (
        .en_n       (en_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .pstrb_n    (pstrb_n),
        .cstrb_n    (cstrb_n),
        .adv_n      (adv_n),
        .gwr_n      (gwr_n),
        .bwr_n      (bwr_n),
        .lane_n     (lane_n),
        .burst_live (state_q == ST_BURST),
        .kind       (kind_now)
    );

    lane_wr_gen #(.LANES(LANES)) u_lanes (
        .kind   (kind_now),
        .gwr_n  (gwr_n),
        .bwr_n  (bwr_n),
        .lane_n (lane_n),
        .wr     (wr_now)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kind_now == CYC_RD_BEG || kind_now == CYC_WR_BEG) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (kind_now == CYC_DESEL) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_kind  <= CYC_DESEL;
            load_addr <= 1'b0;
            advance   <= 1'b0;
            lane_wr   <= '0;
        end else begin
            cyc_kind  <= kind_now;
            load_addr <= (kind_now == CYC_RD_BEG) || (kind_now == CYC_WR_BEG);
            advance   <= (kind_now == CYC_CONT);
            lane_wr   <= wr_now;
        end
    end

    assign chip_active = (state_q == ST_BURST);

    // R3: a read begin never strobes a lane
    p_rd_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CYC_RD_BEG) |-> (lane_wr == '0));

    // R9: a no-op issues nothing and leaves the chip inactive
    p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CYC_NOP) |-> (lane_wr == '0 && !advance && !load_addr && !chip_active));

    // R6: global write strobes every lane in any write-capable cycle
    p_gw_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(gwr_n) && (cyc_kind == CYC_WR_BEG || cyc_kind == CYC_CONT || cyc_kind == CYC_SUSP))
        |-> (&lane_wr));

    // R2: load and advance never pulse together
    p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_addr, advance}));

    // R10: deselect clears the active flag, a begin sets it
    p_desel_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CYC_DESEL) |-> !chip_active);

    p_begin_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_addr |-> chip_active);
endmodule

// File: tb/sram_cycle_decoder_tb.sv
module sram_cycle_decoder_tb_top;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
    logic             pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
    logic             gwr_n = 1'b1, bwr_n = 1'b1;
    logic [LANES-1:0] lane_n = '1;
    logic [2:0]       cyc_kind;
    logic             load_addr, advance, chip_active;
    logic [LANES-1:0] lane_wr;

    int checks = 0;
    int errors = 0;
    int mdl_act = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_cycle_decoder #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .gwr_n(gwr_n),
        .bwr_n(bwr_n), .lane_n(lane_n), .cyc_kind(cyc_kind), .load_addr(load_addr),
        .advance(advance), .lane_wr(lane_wr), .chip_active(chip_active)
    );

    task automatic compare(string tag, int ek, int el, int ea, int ew, int eact);
        checks++;
        if (cyc_kind != ek || load_addr != el || advance != ea || lane_wr != ew || chip_active != eact) begin
            errors++;
            $display("FAIL %s: kind/load/adv/wr/act = %0d/%0d/%0d/%h/%0d expected %0d/%0d/%0d/%h/%0d",
                     tag, cyc_kind, load_addr, advance, lane_wr, chip_active, ek, el, ea, ew, eact);
        end
    endtask

    // behavioural reference: one edge with the given pins
    task automatic step(string tag, bit e, bit sh, bit sl, bit ps, bit cs, bit av,
                        bit gw, bit bw, logic [LANES-1:0] ln);
        int k, w, ld, ad;
        bit sel;
        en_n = e; sel_hi = sh; sel_lo_n = sl; pstrb_n = ps; cstrb_n = cs;
        adv_n = av; gwr_n = gw; bwr_n = bw; lane_n = ln;
        sel = (e == 0) && (sh == 1) && (sl == 0);
        if (cs == 0 && e == 1) k = 0;
        else if (e == 0 && (ps == 0 || cs == 0)) begin
            if (!sel) k = 0;
            else if (ps == 0) k = 1;
            else if (gw == 0 || (bw == 0 && ln != '1)) k = 2;
            else k = 1;
        end else if (mdl_act == 0) k = 5;
        else k = (av == 0) ? 3 : 4;
        w = 0;
        if (k == 2 || k == 3 || k == 4) begin
            for (int i = 0; i < LANES; i++)
                if (gw == 0 || (bw == 0 && ln[i] == 0)) w = w | (1 << i);
        end
        ld = (k == 1 || k == 2) ? 1 : 0;
        ad = (k == 3) ? 1 : 0;
        if (ld == 1) mdl_act = 1;
        else if (k == 0) mdl_act = 0;
        @(posedge clk);
        @(negedge clk);
        compare(tag, k, ld, ad, w, mdl_act);
    endtask

    initial begin
        int seed;
        @(negedge clk);
        @(negedge clk);
        compare("R1 reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step("R9 cont when idle", 0, 1, 0, 1, 1, 0, 1, 1, 4'hF);
        step("R3 pstrb start ignores gw", 0, 1, 0, 0, 1, 1, 0, 0, 4'h0);
        step("R11 write after pstrb start", 0, 1, 0, 1, 1, 1, 0, 1, 4'hF);
        step("R7 byte lanes 0101", 0, 1, 0, 1, 1, 0, 1, 0, 4'b0101);
        step("R7 bwe blocks lanes", 0, 1, 0, 1, 1, 0, 1, 1, 4'h0);
        step("R5 en high continue", 1, 0, 1, 0, 1, 0, 1, 1, 4'hF);
        step("R5 suspend", 1, 0, 1, 1, 1, 1, 1, 0, 4'b1100);
        step("R2 en high cstrb deselect", 1, 1, 0, 1, 0, 0, 0, 0, 4'h0);
        step("R9 suspend when idle", 0, 1, 0, 1, 1, 1, 0, 0, 4'h0);
        step("R4 cstrb byte write", 0, 1, 0, 1, 0, 1, 1, 0, 4'b1110);
        step("R4 cstrb no lane read", 0, 1, 0, 1, 0, 1, 1, 0, 4'hF);
        step("R4 cstrb bwe high read", 0, 1, 0, 1, 0, 1, 1, 1, 4'h0);
        step("R2 sel_hi low deselect", 0, 0, 0, 0, 1, 1, 1, 1, 4'hF);
        step("R2 sel_lo_n high deselect", 0, 1, 1, 1, 0, 1, 0, 1, 4'hF);
        step("R6 cstrb global write", 0, 1, 0, 1, 0, 1, 0, 1, 4'hF);
        step("R3 both strobes read", 0, 1, 0, 0, 0, 1, 0, 0, 4'h0);
        step("R6 gw overrides bwe", 1, 0, 0, 1, 1, 0, 0, 1, 4'hF);
        step("R10 deselect clears", 0, 1, 1, 0, 1, 1, 1, 1, 4'hF);
        step("R8 lane width idle", 0, 1, 0, 1, 1, 0, 1, 0, 4'h0);
        seed = 32'h1ACE;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            seed = seed * 1103515245 + 12345;
            r = seed;
            step("R5 mixed stream", r[20], r[21] | r[27], r[22] & r[28], r[23] | r[29] | r[30],
                 r[24] | r[31], r[25], r[26] | r[19], r[18], r[17:14]);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule